// File: doc/BRIEF.md
# Multithreaded Instruction Issue Scheduler

This block decides, on every clock cycle, which of the hardware thread contexts of a multithreaded core may issue an instruction. Each thread has its own program counter and register bank elsewhere in the core, so moving from one thread to another in consecutive cycles costs no extra cycles. The block only names the thread for the slot and says whether that slot really issues.

The order of issue slots comes from a schedule table that software writes. Each entry holds a thread number. A slot pointer steps through the entries once per cycle and returns to entry 0 after a programmable final entry. The number of entries that hold a thread sets that thread's share of the issue bandwidth. When the thread in the current slot is disabled or not ready, the slot stays empty. The slot is never handed to another thread, so the timing of every other thread stays exactly as programmed.

Writes to the table and to the final-entry index go into a staging copy. The staging copy is moved into the active copy only when the pointer wraps, so a single pass never mixes old and new entries.

Top module: `thread_issue_sched`

## Requirements
- R1: After synchronous reset the pointer is at entry 0, every active and staged entry holds thread 0, and the final-entry index is TABLE_DEPTH-1 (63 by default). A fully enabled core therefore issues thread 0 in every cycle.
- R2: The slot pointer advances by one entry per cycle. In the cycle after it points at the active final entry, it points at entry 0.
- R3: In every cycle, `issue_tid` equals the active table entry at the slot pointer, including cycles in which nothing issues.
- R4: `issue_valid` is 1 exactly when bit `issue_tid` of `thread_en` and bit `issue_tid` of `thread_rdy` are both 1. Otherwise the slot is a bubble and is not given to any other thread.
- R5: A table write (`tbl_we` high at a clock edge stores `tbl_tid` at entry `tbl_addr`) changes no issued thread until the pointer next wraps. From the first slot of the following pass onward the new entry is in effect. A write at the same edge as a wrap takes effect one wrap later.
- R6: A final-entry write (`last_we` high at a clock edge stages `last_idx`) leaves the current pass length unchanged and sets the length from the next pass, with the same wrap-edge rule as R5.
- R7: Two consecutive slots may issue two different threads with no empty cycle between them.
- R8: Over one full pass with all threads enabled and ready, each thread issues exactly as many times as the number of active entries that hold its number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| thread_en | input | NUM_THREADS | Per-thread enable, bit n for thread n |
| thread_rdy | input | NUM_THREADS | Per-thread ready, bit n for thread n |
| tbl_we | input | 1 | Schedule entry write strobe |
| tbl_addr | input | IDX_W (6) | Entry index to write |
| tbl_tid | input | TID_W (3) | Thread number to store |
| last_we | input | 1 | Final-entry index write strobe |
| last_idx | input | IDX_W (6) | New final-entry index |
| issue_valid | output | 1 | This cycle's slot issues |
| issue_tid | output | TID_W (3) | Thread that owns this cycle's slot |

## Verification
The bench builds the block with its default eight threads and 64 entries. At this size every final-entry index from 0 to 63 can be swept, and for each one the table is reprogrammed in the middle of a pass. This reaches the single-entry table, the full-depth table, and writes that land on the wrap edge itself. Pseudo-random enable and ready patterns cover every thread's bubble and issue cases. An arithmetic model of the staged and active copies predicts each cycle's thread and valid, and the per-thread issue counts of each pass are compared with the entry counts.

// File: rtl/sched_pkg.sv
package sched_pkg;

    localparam int unsigned DEF_THREADS = 8;
    localparam int unsigned DEF_DEPTH   = 64;

    typedef enum logic [1:0] {
        SLOT_ISSUE = 2'd0,
        SLOT_OFF   = 2'd1,
        SLOT_STALL = 2'd2
    } slot_state_e;

    function automatic int unsigned field_width(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/sched_pointer.sv
module sched_pointer #(
    parameter int unsigned TABLE_DEPTH = sched_pkg::DEF_DEPTH,
    localparam int unsigned IDX_W = sched_pkg::field_width(TABLE_DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             last_we,
    input  logic [IDX_W-1:0] last_idx,
    output logic [IDX_W-1:0] slot_ptr,
    output logic [IDX_W-1:0] last_act,
    output logic             wrap
);
    localparam logic [IDX_W-1:0] LAST_MAX = IDX_W'(TABLE_DEPTH - 1);

    logic [IDX_W-1:0] last_stage;
    logic [IDX_W-1:0] last_clamped;

    assign last_clamped = (last_idx > LAST_MAX) ? LAST_MAX : last_idx;
    assign wrap         = (slot_ptr == last_act);

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_ptr   <= '0;
            last_stage <= LAST_MAX;
            last_act   <= LAST_MAX;
        end else begin
            if (last_we) begin
                last_stage <= last_clamped;
            end
            if (wrap) begin
                slot_ptr <= '0;
                last_act <= last_stage;
            end else begin
                slot_ptr <= slot_ptr + IDX_W'(1);
            end
        end
    end

endmodule

// File: rtl/sched_table.sv
module sched_table #(
    parameter int unsigned NUM_THREADS = sched_pkg::DEF_THREADS,
    parameter int unsigned TABLE_DEPTH = sched_pkg::DEF_DEPTH,
    localparam int unsigned TID_W = sched_pkg::field_width(NUM_THREADS),
    localparam int unsigned IDX_W = sched_pkg::field_width(TABLE_DEPTH)
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              tbl_we,
    input  logic [IDX_W-1:0]                  tbl_addr,
    input  logic [TID_W-1:0]                  tbl_tid,
    input  logic                              commit,
    input  logic [IDX_W-1:0]                  rd_idx,
    output logic [TID_W-1:0]                  rd_tid,
    output logic [TABLE_DEPTH-1:0][TID_W-1:0] act_tbl
);
    logic [TABLE_DEPTH-1:0][TID_W-1:0] stg_tbl;

    for (genvar e = 0; e < TABLE_DEPTH; e++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                stg_tbl[e] <= '0;
                act_tbl[e] <= '0;
            end else begin
                if (tbl_we && (tbl_addr == IDX_W'(e))) begin
                    stg_tbl[e] <= tbl_tid;
                end
                if (commit) begin
                    act_tbl[e] <= stg_tbl[e];
                end
            end
        end
    end

    assign rd_tid = act_tbl[rd_idx];

endmodule

// File: rtl/sched_gate.sv
module sched_gate #(
    parameter int unsigned NUM_THREADS = sched_pkg::DEF_THREADS,
    localparam int unsigned TID_W = sched_pkg::field_width(NUM_THREADS)
) (
    input  logic [NUM_THREADS-1:0] thread_en,
    input  logic [NUM_THREADS-1:0] thread_rdy,
    input  logic [TID_W-1:0]       slot_tid,
    output sched_pkg::slot_state_e slot_state
);
    always_comb begin
        if (!thread_en[slot_tid]) begin
            slot_state = sched_pkg::SLOT_OFF;
        end else if (!thread_rdy[slot_tid]) begin
            slot_state = sched_pkg::SLOT_STALL;
        end else begin
            slot_state = sched_pkg::SLOT_ISSUE;
        end
    end

endmodule

// File: rtl/thread_issue_sched.sv
module thread_issue_sched #(
    parameter int unsigned NUM_THREADS = sched_pkg::DEF_THREADS,
    parameter int unsigned TABLE_DEPTH = sched_pkg::DEF_DEPTH,
    localparam int unsigned TID_W = sched_pkg::field_width(NUM_THREADS),
    localparam int unsigned IDX_W = sched_pkg::field_width(TABLE_DEPTH)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NUM_THREADS-1:0] thread_en,
    input  logic [NUM_THREADS-1:0] thread_rdy,
    input  logic                   tbl_we,
    input  logic [IDX_W-1:0]       tbl_addr,
    input  logic [TID_W-1:0]       tbl_tid,
    input  logic                   last_we,
    input  logic [IDX_W-1:0]       last_idx,
    output logic                   issue_valid,
    output logic [TID_W-1:0]       issue_tid
);
    logic [IDX_W-1:0]                  slot_ptr;
    logic [IDX_W-1:0]                  last_act;
    logic                              wrap;
    logic [TABLE_DEPTH-1:0][TID_W-1:0] act_tbl;
    sched_pkg::slot_state_e            slot_state;

    sched_pointer #(.TABLE_DEPTH(TABLE_DEPTH)) u_ptr (
        .clk      (clk),
        .rst      (rst),
        .last_we  (last_we),
        .last_idx (last_idx),
        .slot_ptr (slot_ptr),
        .last_act (last_act),
        .wrap     (wrap)
    );

    sched_table #(.NUM_THREADS(NUM_THREADS), .TABLE_DEPTH(TABLE_DEPTH)) u_tbl (
        .clk      (clk),
        .rst      (rst),
        .tbl_we   (tbl_we),
        .tbl_addr (tbl_addr),
        .tbl_tid  (tbl_tid),
        .commit   (wrap),
        .rd_idx   (slot_ptr),
        .rd_tid   (issue_tid),
        .act_tbl  (act_tbl)
    );

    sched_gate #(.NUM_THREADS(NUM_THREADS)) u_gate (
        .thread_en  (thread_en),
        .thread_rdy (thread_rdy),
        .slot_tid   (issue_tid),
        .slot_state (slot_state)
    );

    assign issue_valid = (slot_state == sched_pkg::SLOT_ISSUE);

endmodule

// File: rtl/sched_checker.sv
module sched_checker #(
    parameter int unsigned NUM_THREADS = sched_pkg::DEF_THREADS,
    parameter int unsigned TABLE_DEPTH = sched_pkg::DEF_DEPTH,
    localparam int unsigned TID_W = sched_pkg::field_width(NUM_THREADS),
    localparam int unsigned IDX_W = sched_pkg::field_width(TABLE_DEPTH)
) (
    input logic                              clk,
    input logic                              rst,
    input logic [NUM_THREADS-1:0]            thread_en,
    input logic [NUM_THREADS-1:0]            thread_rdy,
    input logic                              issue_valid,
    input logic [TID_W-1:0]                  issue_tid,
    input logic [IDX_W-1:0]                  slot_ptr,
    input logic [IDX_W-1:0]                  last_act,
    input logic [TABLE_DEPTH-1:0][TID_W-1:0] act_tbl
);
    p_reset_ptr_r1: assert property (@(posedge clk)
        rst |=> (slot_ptr == '0) && (last_act == IDX_W'(TABLE_DEPTH - 1)));

    p_step_r2: assert property (@(posedge clk) disable iff (rst)
        (slot_ptr != last_act) |=> (slot_ptr == $past(slot_ptr) + IDX_W'(1)));

    p_wrap_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (slot_ptr == last_act) |=> (slot_ptr == '0));

    p_ptr_bound_r2: assert property (@(posedge clk) disable iff (rst)
        slot_ptr <= last_act);

    p_issue_gate_r4: assert property (@(posedge clk) disable iff (rst)
        issue_valid |-> (thread_en[issue_tid] && thread_rdy[issue_tid]));

    p_bubble_r4: assert property (@(posedge clk) disable iff (rst)
        (thread_en[issue_tid] && thread_rdy[issue_tid]) |-> issue_valid);

    p_table_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (slot_ptr != last_act) |=> $stable(act_tbl));

    p_last_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (slot_ptr != last_act) |=> $stable(last_act));

endmodule

bind thread_issue_sched sched_checker #(
    .NUM_THREADS (NUM_THREADS),
    .TABLE_DEPTH (TABLE_DEPTH)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .thread_en   (thread_en),
    .thread_rdy  (thread_rdy),
    .issue_valid (issue_valid),
    .issue_tid   (issue_tid),
    .slot_ptr    (slot_ptr),
    .last_act    (last_act),
    .act_tbl     (act_tbl)
);

// File: tb/thread_issue_sched_bench.sv
module thread_issue_sched_bench;
    localparam int NT = 8;
    localparam int DEPTH = 64;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NT-1:0] thread_en = '1;
    logic [NT-1:0] thread_rdy = '1;
    logic          tbl_we = 1'b0;
    logic [5:0]    tbl_addr = '0;
    logic [2:0]    tbl_tid = '0;
    logic          last_we = 1'b0;
    logic [5:0]    last_idx = '0;
    logic          issue_valid;
    logic [2:0]    issue_tid;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    int m_stg [DEPTH];
    int m_act [DEPTH];
    int m_ptr, m_last, m_last_stg;
    logic [15:0] lfsr = 16'hACE1;

    always #10 clk = ~clk;

    thread_issue_sched u_thread_issue_sched (
        .clk(clk), .rst(rst), .thread_en(thread_en), .thread_rdy(thread_rdy),
        .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_tid(tbl_tid),
        .last_we(last_we), .last_idx(last_idx),
        .issue_valid(issue_valid), .issue_tid(issue_tid)
    );

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        while (cycles < 150000) begin
            @(posedge clk);
            cycles++;
        end
        errors++;
        $display("FAIL watchdog expired: actual %0d cycles expected completion", cycles);
        summary();
    end

    task automatic model_reset();
        for (int i = 0; i < DEPTH; i++) begin
            m_stg[i] = 0;
            m_act[i] = 0;
        end
        m_ptr = 0; m_last = DEPTH - 1; m_last_stg = DEPTH - 1;
    endtask

    // Called just after a falling edge with inputs set; checks, then steps one clock.
    task automatic run_cycle(input string tag);
        int exp_tid;
        logic exp_valid;
        #1;
        exp_tid = m_act[m_ptr];
        exp_valid = thread_en[exp_tid] & thread_rdy[exp_tid];
        checks++;
        if (issue_tid !== 3'(exp_tid) || issue_valid !== exp_valid) begin
            errors++;
            $display("FAIL %s slot %0d: actual tid %0d valid %b expected tid %0d valid %b",
                     tag, m_ptr, issue_tid, issue_valid, exp_tid, exp_valid);
        end
        @(posedge clk);
        #1;
        if (m_ptr == m_last) begin
            m_ptr = 0;
            m_last = m_last_stg;
            for (int i = 0; i < DEPTH; i++) m_act[i] = m_stg[i];
        end else begin
            m_ptr++;
        end
        if (tbl_we) m_stg[tbl_addr] = int'(tbl_tid);
        if (last_we) m_last_stg = int'(last_idx);
        @(negedge clk);
        tbl_we = 1'b0;
        last_we = 1'b0;
    endtask

    task automatic write_entry(input int a, input int t, input string tag);
        tbl_we = 1'b1; tbl_addr = 6'(a); tbl_tid = 3'(t);
        run_cycle(tag);
    endtask

    task automatic write_last(input int l, input string tag);
        last_we = 1'b1; last_idx = 6'(l);
        run_cycle(tag);
    endtask

    task automatic to_pass_start(input string tag);
        while (m_ptr != 0) run_cycle(tag);
    endtask

    // R8: count issues per thread across one whole pass starting at entry 0.
    task automatic share_pass();
        int got [NT];
        int want [NT];
        thread_en = '1; thread_rdy = '1;
        to_pass_start("R8");
        for (int t = 0; t < NT; t++) begin got[t] = 0; want[t] = 0; end
        for (int i = 0; i <= m_last; i++) want[m_act[i]]++;
        for (int i = 0; i <= m_last; i++) begin
            #1;
            if (issue_valid) got[issue_tid]++;
            run_cycle("R8");
        end
        for (int t = 0; t < NT; t++) begin
            checks++;
            if (got[t] != want[t]) begin
                errors++;
                $display("FAIL R8 thread %0d share: actual %0d expected %0d", t, got[t], want[t]);
            end
        end
    endtask

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state, thread 0 everywhere, 64-slot pass
        for (int c = 0; c < 70; c++) run_cycle("R1");
        share_pass();

        // R5: program a round-robin pattern mid-pass; old pattern holds until wrap
        for (int i = 0; i < DEPTH; i++) write_entry(i, i % NT, "R5");
        // R6: shrink pass to 8 entries, staged
        write_last(7, "R6");
        for (int c = 0; c < 140; c++) run_cycle("R6");

        // R7: consecutive slots with different threads, both issuing
        to_pass_start("R7");
        #1;
        checks++;
        if (!(issue_valid && issue_tid == 3'd0)) begin
            errors++;
            $display("FAIL R7 first slot: actual tid %0d valid %b expected tid 0 valid 1",
                     issue_tid, issue_valid);
        end
        run_cycle("R7");
        #1;
        checks++;
        if (!(issue_valid && issue_tid == 3'd1)) begin
            errors++;
            $display("FAIL R7 second slot: actual tid %0d valid %b expected tid 1 valid 1",
                     issue_tid, issue_valid);
        end
        run_cycle("R7");

        // R4: disabled / stalled threads leave bubbles, no reassignment
        thread_en = 8'b1111_1101;
        thread_rdy = 8'b1110_1111;
        for (int c = 0; c < 40; c++) run_cycle("R4");

        // R2/R3/R5/R6 sweep over every final-entry index with random flags
        for (int l = 0; l < DEPTH; l++) begin
            write_last(l, "R6");
            for (int k = 0; k < 6; k++) begin
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                thread_en = lfsr[7:0] | 8'h11;
                thread_rdy = lfsr[15:8] | 8'h21;
                write_entry((l * 5 + k * 11) % DEPTH, (l + k * 3) % NT, "R5");
            end
            for (int c = 0; c < 2 * l + 4; c++) begin
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                thread_en = lfsr[7:0];
                thread_rdy = lfsr[15:8];
                run_cycle("R3");
            end
        end

        // R5: a write landing on the wrap edge waits one further wrap
        write_last(3, "R6");
        for (int c = 0; c < 140; c++) run_cycle("R2");
        while (m_ptr != m_last) run_cycle("R2");
        write_entry(0, 6, "R5");
        for (int c = 0; c < 12; c++) run_cycle("R5");

        // R2: single-entry table and weighted shares
        write_last(0, "R2");
        for (int c = 0; c < 80; c++) run_cycle("R2");
        for (int i = 0; i < 10; i++) write_entry(i, (i % 3 == 0) ? 0 : (i % 5), "R8");
        write_last(9, "R8");
        for (int c = 0; c < 20; c++) run_cycle("R8");
        share_pass();
        write_last(63, "R2");
        for (int c = 0; c < 140; c++) run_cycle("R2");
        share_pass();

        summary();
    end
endmodule